// File: doc/BRIEF.md
# Register-Direct Two-Operand ALU Executor

This block decodes and runs a small set of 32-bit two-operand integer instructions in which both operands sit in an eight-entry register file. Instruction bytes come in one at a time over a valid/ready byte port. The first byte is an opcode, or a two-byte escape pair for the multiply form. The byte that follows selects the two registers. When that last byte is accepted, the block reads both registers, computes the result, writes it back to the register the opcode names, updates the status flags (sign, zero, signed overflow) and pulses `done` on the next cycle.

In the selector byte, bits 7:6 give the addressing mode, bits 5:3 the "reg" operand and bits 2:0 the "r/m" operand. Only mode 3 (both operands in registers) is executed. Any other mode, an unknown opcode or a broken escape pair sets a sticky error flag and changes no register or flag. Register numbers 0 to 7 stand for the accumulator, counter, data, base, stack pointer, frame pointer, source index and destination index. A side port loads and reads registers directly, and the surrounding logic uses it to set up and observe operands.

Top module: `regdir_alu_exec`

## Requirements
- R1: After reset all eight registers read 0, the flags `sf`, `zf` and `of` are 0, `err` and `done` are 0, and `in_ready` is 1 from the first clock edge after reset is released.
- R2: A byte is taken on a rising edge when `in_valid` and `in_ready` are both high. Idle cycles between bytes are allowed. `done` is high for exactly one cycle, in the cycle after the edge that takes the selector byte of a legal instruction. The selector is {mode[7:6], reg[5:3], rm[2:0]}.
- R3: Opcodes 0x01 (add), 0x29 (subtract), 0x21 (AND), 0x09 (OR) and 0x31 (XOR) write `rm op reg` into register rm, with subtract computing rm minus reg. Example: rm=0x10, reg=1 under 0x01 gives 0x00000011.
- R4: For add, subtract, the bitwise ops and multiply, `sf` takes bit 31 of the result and `zf` is set when the result is zero. `of` is set on signed overflow for add and subtract and is cleared by the bitwise ops.
- R5: Opcode 0x39 computes rm minus reg and sets the flags exactly as subtract does. It writes no register.
- R6: Opcode 0x89 copies register reg into register rm and leaves the flags unchanged.
- R7: Opcode 0x87 exchanges registers reg and rm (no change when they are the same register) and leaves the flags unchanged.
- R8: The byte pair 0x0F 0xAF writes the low 32 bits of the signed product reg*rm into register reg. `sf` and `zf` come from those low bits. `of` is set when the signed product does not fit in 32 bits.
- R9: A selector byte whose mode is not 3 sets `err`, gives no `done` pulse and leaves all registers and flags unchanged. `err` stays set until reset.
- R10: An opcode byte outside the listed set, or 0x0F followed by any byte other than 0xAF, sets `err` and changes nothing. The decoder then expects a fresh opcode byte.
- R11: `ld_en` writes `ld_data` into register `ld_idx` at the clock edge. `rd_data` shows register `rd_idx` without delay. If an instruction write-back hits the same register in the same cycle, the instruction result is kept; a load to a different register takes effect alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte |
| ld_en | input | 1 | Direct register load strobe |
| ld_idx | input | 3 | Register number to load |
| ld_data | input | DATA_W | Value to load |
| rd_idx | input | 3 | Register number to observe |
| rd_data | output | DATA_W | Contents of register rd_idx |
| done | output | 1 | One-cycle pulse after each executed instruction |
| err | output | 1 | Sticky decode error |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| of | output | 1 | Signed-overflow flag |

## Verification
A direct register load and an instruction write-back can occur on the same edge, and they can target the same register or different ones. The bench sets this up by raising `ld_en` in the same cycle it presents the selector byte of an add. It then reads the register file back through `rd_data`. When both target the same register, only the sum must remain. When they target different registers, both the sum and the loaded word must be present.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

   localparam int RIDX_W = 3;

   typedef enum logic [3:0] {
      OPK_ADD, OPK_SUB, OPK_AND, OPK_OR, OPK_XOR,
      OPK_CMP, OPK_MOV, OPK_XCHG, OPK_IMUL
   } opk_e;

   typedef enum logic [1:0] {
      DS_OPC, DS_ESC, DS_SEL
   } dstate_e;

   localparam logic [7:0] BYTE_ADD   = 8'h01;
   localparam logic [7:0] BYTE_SUB   = 8'h29;
   localparam logic [7:0] BYTE_AND   = 8'h21;
   localparam logic [7:0] BYTE_OR    = 8'h09;
   localparam logic [7:0] BYTE_XOR   = 8'h31;
   localparam logic [7:0] BYTE_CMP   = 8'h39;
   localparam logic [7:0] BYTE_MOV   = 8'h89;
   localparam logic [7:0] BYTE_XCHG  = 8'h87;
   localparam logic [7:0] BYTE_ESC   = 8'h0F;
   localparam logic [7:0] BYTE_IMUL2 = 8'hAF;
   localparam logic [1:0] MODE_REG   = 2'b11;

endpackage

// File: rtl/rdx_decode.sv
module rdx_decode
   import rdx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   output logic              exec_go,
   output opk_e              exec_op,
   output logic [RIDX_W-1:0] exec_rg,
   output logic [RIDX_W-1:0] exec_rm,
   output logic              bad_evt
);

   dstate_e st_q, st_n;
   opk_e    op_q, op_n;
   logic    rdy_q;
   logic    take;

   assign take     = in_valid && rdy_q;
   assign in_ready = rdy_q;
   assign exec_op  = op_q;
   assign exec_rg  = in_byte[5:3];
   assign exec_rm  = in_byte[2:0];

   always_comb begin
      st_n    = st_q;
      op_n    = op_q;
      exec_go = 1'b0;
      bad_evt = 1'b0;
      if (take) begin
         case (st_q)
            DS_OPC: begin
               st_n = DS_SEL;
               case (in_byte)
                  BYTE_ADD:  op_n = OPK_ADD;
                  BYTE_SUB:  op_n = OPK_SUB;
                  BYTE_AND:  op_n = OPK_AND;
                  BYTE_OR:   op_n = OPK_OR;
                  BYTE_XOR:  op_n = OPK_XOR;
                  BYTE_CMP:  op_n = OPK_CMP;
                  BYTE_MOV:  op_n = OPK_MOV;
                  BYTE_XCHG: op_n = OPK_XCHG;
                  BYTE_ESC:  st_n = DS_ESC;
                  default: begin
                     st_n    = DS_OPC;
                     bad_evt = 1'b1;
                  end
               endcase
            end
            DS_ESC: begin
               if (in_byte == BYTE_IMUL2) begin
                  op_n = OPK_IMUL;
                  st_n = DS_SEL;
               end else begin
                  bad_evt = 1'b1;
                  st_n    = DS_OPC;
               end
            end
            DS_SEL: begin
               st_n = DS_OPC;
               if (in_byte[7:6] == MODE_REG) exec_go = 1'b1;
               else                          bad_evt = 1'b1;
            end
            default: st_n = DS_OPC;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= DS_OPC;
         op_q  <= OPK_ADD;
         rdy_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         op_q  <= op_n;
         rdy_q <= 1'b1;
      end
   end

endmodule

// File: rtl/rdx_alu.sv
module rdx_alu
   import rdx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int MUL_IMPL = 0
)(
   input  opk_e              op,
   input  logic [DATA_W-1:0] a_rm,
   input  logic [DATA_W-1:0] b_rg,
   output logic [DATA_W-1:0] rm_val,
   output logic [DATA_W-1:0] rg_val,
   output logic              rm_we,
   output logic              rg_we,
   output logic              flg_we,
   output logic              sf,
   output logic              zf,
   output logic              of
);

   localparam int MSB = DATA_W - 1;
   localparam int PW  = 2 * DATA_W;

   logic [DATA_W-1:0] sum, dif, res;
   logic [PW-1:0]     ext_a, ext_b, prod;
   logic              ovf, add_ovf, sub_ovf, mul_ovf;

   assign sum   = a_rm + b_rg;
   assign dif   = a_rm - b_rg;
   assign ext_a = {{DATA_W{a_rm[MSB]}}, a_rm};
   assign ext_b = {{DATA_W{b_rg[MSB]}}, b_rg};

   generate
      if (MUL_IMPL == 0) begin : g_mul_op
         assign prod = ext_a * ext_b;
      end else begin : g_mul_shadd
         always_comb begin
            prod = '0;
            for (int i = 0; i < PW; i++) begin
               if (ext_b[i]) prod = prod + (ext_a << i);
            end
         end
      end
   endgenerate

   assign add_ovf = (a_rm[MSB] == b_rg[MSB]) && (sum[MSB] != a_rm[MSB]);
   assign sub_ovf = (a_rm[MSB] != b_rg[MSB]) && (dif[MSB] != a_rm[MSB]);
   assign mul_ovf = (prod[PW-1:DATA_W] != {DATA_W{prod[MSB]}});

   always_comb begin
      rm_val = b_rg;
      rg_val = a_rm;
      rm_we  = 1'b0;
      rg_we  = 1'b0;
      flg_we = 1'b0;
      res    = sum;
      ovf    = 1'b0;
      case (op)
         OPK_ADD: begin
            res = sum; ovf = add_ovf; rm_val = sum; rm_we = 1'b1; flg_we = 1'b1;
         end
         OPK_SUB: begin
            res = dif; ovf = sub_ovf; rm_val = dif; rm_we = 1'b1; flg_we = 1'b1;
         end
         OPK_AND: begin
            res = a_rm & b_rg; rm_val = a_rm & b_rg; rm_we = 1'b1; flg_we = 1'b1;
         end
         OPK_OR: begin
            res = a_rm | b_rg; rm_val = a_rm | b_rg; rm_we = 1'b1; flg_we = 1'b1;
         end
         OPK_XOR: begin
            res = a_rm ^ b_rg; rm_val = a_rm ^ b_rg; rm_we = 1'b1; flg_we = 1'b1;
         end
         OPK_CMP: begin
            res = dif; ovf = sub_ovf; flg_we = 1'b1;
         end
         OPK_MOV: begin
            rm_val = b_rg; rm_we = 1'b1;
         end
         OPK_XCHG: begin
            rm_val = b_rg; rg_val = a_rm; rm_we = 1'b1; rg_we = 1'b1;
         end
         OPK_IMUL: begin
            res = prod[MSB:0]; ovf = mul_ovf; rg_val = prod[MSB:0];
            rg_we = 1'b1; flg_we = 1'b1;
         end
         default: ;
      endcase
   end

   assign sf = res[MSB];
   assign zf = (res == '0);
   assign of = ovf;

endmodule

// File: rtl/rdx_regfile.sv
module rdx_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 8,
   localparam int IW    = $clog2(NREG)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IW-1:0]     ra_idx,
   output logic [DATA_W-1:0] ra_dat,
   input  logic [IW-1:0]     rb_idx,
   output logic [DATA_W-1:0] rb_dat,
   input  logic [IW-1:0]     rx_idx,
   output logic [DATA_W-1:0] rx_dat,
   input  logic              wa_en,
   input  logic [IW-1:0]     wa_idx,
   input  logic [DATA_W-1:0] wa_dat,
   input  logic              wb_en,
   input  logic [IW-1:0]     wb_idx,
   input  logic [DATA_W-1:0] wb_dat,
   input  logic              wl_en,
   input  logic [IW-1:0]     wl_idx,
   input  logic [DATA_W-1:0] wl_dat
);

   logic [NREG-1:0][DATA_W-1:0] flat;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_ent
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                   q <= '0;
            else if (wa_en && (wa_idx == IW'(g)))         q <= wa_dat;
            else if (wb_en && (wb_idx == IW'(g)))         q <= wb_dat;
            else if (wl_en && (wl_idx == IW'(g)))         q <= wl_dat;
         end
         assign flat[g] = q;
      end
   endgenerate

   assign ra_dat = flat[ra_idx];
   assign rb_dat = flat[rb_idx];
   assign rx_dat = flat[rx_idx];

endmodule

// File: rtl/regdir_alu_exec.sv
module regdir_alu_exec
   import rdx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int MUL_IMPL = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   input  logic              ld_en,
   input  logic [2:0]        ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [2:0]        rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              err,
   output logic              sf,
   output logic              zf,
   output logic              of
);

   localparam int NREG = 1 << RIDX_W;

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (MUL_IMPL == 0 || MUL_IMPL == 1) else $error("MUL_IMPL must be 0 or 1");
   end

   logic              exec_go, bad_evt;
   opk_e              exec_op;
   logic [RIDX_W-1:0] exec_rg, exec_rm;
   logic [DATA_W-1:0] rm_dat, rg_dat, rm_val, rg_val;
   logic              rm_we, rg_we, flg_we, a_sf, a_zf, a_of;
   logic              done_q, err_q, sf_q, zf_q, of_q;

   rdx_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .in_ready (in_ready),
      .exec_go  (exec_go),
      .exec_op  (exec_op),
      .exec_rg  (exec_rg),
      .exec_rm  (exec_rm),
      .bad_evt  (bad_evt)
   );

   rdx_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (exec_rm),
      .ra_dat (rm_dat),
      .rb_idx (exec_rg),
      .rb_dat (rg_dat),
      .rx_idx (rd_idx),
      .rx_dat (rd_data),
      .wa_en  (exec_go && rm_we),
      .wa_idx (exec_rm),
      .wa_dat (rm_val),
      .wb_en  (exec_go && rg_we),
      .wb_idx (exec_rg),
      .wb_dat (rg_val),
      .wl_en  (ld_en),
      .wl_idx (ld_idx),
      .wl_dat (ld_data)
   );

   rdx_alu #(.DATA_W(DATA_W), .MUL_IMPL(MUL_IMPL)) u_alu (
      .op     (exec_op),
      .a_rm   (rm_dat),
      .b_rg   (rg_dat),
      .rm_val (rm_val),
      .rg_val (rg_val),
      .rm_we  (rm_we),
      .rg_we  (rg_we),
      .flg_we (flg_we),
      .sf     (a_sf),
      .zf     (a_zf),
      .of     (a_of)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         sf_q   <= 1'b0;
         zf_q   <= 1'b0;
         of_q   <= 1'b0;
      end else begin
         done_q <= exec_go;
         if (bad_evt) err_q <= 1'b1;
         if (exec_go && flg_we) begin
            sf_q <= a_sf;
            zf_q <= a_zf;
            of_q <= a_of;
         end
      end
   end

   assign done = done_q;
   assign err  = err_q;
   assign sf   = sf_q;
   assign zf   = zf_q;
   assign of   = of_q;

endmodule

// File: rtl/rdx_chk.sv
module rdx_chk (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic done,
   input logic err,
   input logic sf,
   input logic zf,
   input logic exec_go,
   input logic bad_evt
);

   p_done_after_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exec_go |=> done);

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_go_bad_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_go && bad_evt));

   p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> in_ready);

   p_zero_not_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      zf |-> !sf);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   p_bad_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_evt |=> !done);

   p_bad_sets_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bad_evt |=> err);

endmodule

bind regdir_alu_exec rdx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .done     (done),
   .err      (err),
   .sf       (sf),
   .zf       (zf),
   .exec_go  (exec_go),
   .bad_evt  (bad_evt)
);

// File: tb/regdir_alu_exec_tb.sv
module regdir_alu_exec_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_ready;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = 3'd0;
   logic [31:0] ld_data = 32'd0;
   logic [2:0]  rd_idx = 3'd0;
   logic [31:0] rd_data;
   logic        done, err, sf, zf, of;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] e [8];
   logic esf = 1'b0, ezf = 1'b0, eof = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regdir_alu_exec u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .err(err),
      .sf(sf), .zf(zf), .of(of)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      tick();
      in_valid = 1'b0;
   endtask

   task automatic load(input int idx, input logic [31:0] v);
      ld_en = 1'b1; ld_idx = idx[2:0]; ld_data = v;
      tick();
      ld_en = 1'b0;
      e[idx] = v;
   endtask

   task automatic get(input int idx, output logic [31:0] v);
      rd_idx = idx[2:0];
      #1;
      v = rd_data;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; ld_en = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) e[i] = 32'd0;
      esf = 1'b0; ezf = 1'b0; eof = 1'b0;
      tick();
   endtask

   function automatic logic [7:0] opc(input int k);
      case (k)
         0: opc = 8'h01; 1: opc = 8'h29; 2: opc = 8'h21; 3: opc = 8'h09;
         4: opc = 8'h31; 5: opc = 8'h39; 6: opc = 8'h89; 7: opc = 8'h87;
         default: opc = 8'hAF;
      endcase
   endfunction

   function automatic string tagk(input int k);
      if (k < 5) tagk = "R3";
      else if (k == 5) tagk = "R5";
      else if (k == 6) tagk = "R6";
      else if (k == 7) tagk = "R7";
      else tagk = "R8";
   endfunction

   function automatic void model(input int k, input logic [31:0] a, input logic [31:0] b,
      output logic [31:0] na, output logic [31:0] nb, output logic wa, output logic wb,
      output logic fw, output logic s, output logic z, output logic o);
      longint fa, fb, fr;
      logic [31:0] r;
      fa = longint'($signed(a));
      fb = longint'($signed(b));
      na = a; nb = b; wa = 1'b0; wb = 1'b0; fw = 1'b0; o = 1'b0; r = 32'd0; fr = 0;
      case (k)
         0: begin fr = fa + fb; r = fr[31:0]; o = (fr != longint'($signed(r))); wa = 1; fw = 1; na = r; end
         1: begin fr = fa - fb; r = fr[31:0]; o = (fr != longint'($signed(r))); wa = 1; fw = 1; na = r; end
         2: begin r = a & b; wa = 1; fw = 1; na = r; end
         3: begin r = a | b; wa = 1; fw = 1; na = r; end
         4: begin r = a ^ b; wa = 1; fw = 1; na = r; end
         5: begin fr = fa - fb; r = fr[31:0]; o = (fr != longint'($signed(r))); fw = 1; end
         6: begin na = b; wa = 1; end
         7: begin na = b; nb = a; wa = 1; wb = 1; end
         default: begin fr = fa * fb; r = fr[31:0]; o = (fr != longint'($signed(r))); wb = 1; fw = 1; nb = r; end
      endcase
      s = r[31];
      z = (r == 32'd0);
   endfunction

   task automatic run_ins(input int k, input int rg, input int rm);
      if (k == 8) send(8'h0F);
      send(opc(k));
      send({2'b11, rg[2:0], rm[2:0]});
   endtask

   task automatic exec_check(input int k, input int rg, input int rm);
      logic [31:0] na, nb, rv;
      logic wa, wb, fw, s, z, o;
      model(k, e[rm], e[rg], na, nb, wa, wb, fw, s, z, o);
      run_ins(k, rg, rm);
      if (wa) e[rm] = na;
      if (wb) e[rg] = nb;
      if (fw) begin esf = s; ezf = z; eof = o; end
      chk({tagk(k), " R2 done pulse"}, {31'd0, done}, 32'd1);
      for (int i = 0; i < 8; i++) begin
         get(i, rv);
         chk({tagk(k), " register"}, rv, e[i]);
      end
      chk({tagk(k), " R4 flags sf/zf/of"}, {29'd0, sf, zf, of}, {29'd0, esf, ezf, eof});
   endtask

   function automatic logic [31:0] pat(input int i, input int s);
      logic [31:0] x;
      x = 32'h9E3779B9 * 32'(i + 1 + 8 * s);
      return x ^ (x >> 13);
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rv, cv [5];
      cv[0] = 32'h0; cv[1] = 32'h1; cv[2] = 32'h7FFFFFFF; cv[3] = 32'h80000000; cv[4] = 32'hFFFFFFFF;
      @(negedge clk);
      do_reset();

      // R1 reset state
      for (int i = 0; i < 8; i++) begin get(i, rv); chk("R1 register zero", rv, 32'd0); end
      chk("R1 flags/err/done", {27'd0, sf, zf, of, err, done}, 32'd0);
      chk("R1 in_ready", {31'd0, in_ready}, 32'd1);

      // R3 directed: add 0x10 + 1, OR pattern
      load(0, 32'h10); load(3, 32'h1);
      exec_check(0, 3, 0);
      get(0, rv); chk("R3 add 01 D8", rv, 32'h00000011);
      tick(); chk("R2 done falls", {31'd0, done}, 32'd0);
      load(0, 32'h0A0B0C0D); load(3, 32'hA0B0C0D0);
      exec_check(3, 3, 0);
      get(0, rv); chk("R3 or 09 D8", rv, 32'hAABBCCDD);

      // R2 idle bubbles between bytes
      send(8'h29);
      for (int i = 0; i < 3; i++) begin tick(); chk("R2 no done mid-instruction", {31'd0, done}, 32'd0); end
      begin
         logic [31:0] na, nb; logic wa, wb, fw, s, z, o;
         model(1, e[1], e[2], na, nb, wa, wb, fw, s, z, o);
         send({2'b11, 3'd2, 3'd1});
         e[1] = na; esf = s; ezf = z; eof = o;
         chk("R2 done after bubble", {31'd0, done}, 32'd1);
         get(1, rv); chk("R3 sub after bubble", rv, e[1]);
      end

      // Full sweep: every op over every reg/rm pair (R3 R5 R6 R7 R8)
      for (int k = 0; k < 9; k++)
         for (int rg = 0; rg < 8; rg++)
            for (int rm = 0; rm < 8; rm++) begin
               for (int i = 0; i < 8; i++) load(i, pat(i, k * 64 + rg * 8 + rm));
               exec_check(k, rg, rm);
            end

      // Corner operands for flag behaviour (R4 R5 R8)
      for (int kk = 0; kk < 4; kk++)
         for (int x = 0; x < 5; x++)
            for (int y = 0; y < 5; y++) begin
               load(0, cv[x]); load(3, cv[y]);
               exec_check((kk == 0) ? 0 : (kk == 1) ? 1 : (kk == 2) ? 5 : 8, 3, 0);
            end

      // R11 load and write-back in the same cycle
      load(0, 32'h100); load(3, 32'h23); load(2, 32'h5);
      send(8'h01);
      in_valid = 1'b1; in_byte = {2'b11, 3'd3, 3'd0};
      ld_en = 1'b1; ld_idx = 3'd0; ld_data = 32'hDEADBEEF;
      tick();
      in_valid = 1'b0; ld_en = 1'b0;
      get(0, rv); chk("R11 same register: write-back wins", rv, 32'h123);
      send(8'h01);
      in_valid = 1'b1; in_byte = {2'b11, 3'd3, 3'd0};
      ld_en = 1'b1; ld_idx = 3'd2; ld_data = 32'hCAFEF00D;
      tick();
      in_valid = 1'b0; ld_en = 1'b0;
      get(0, rv); chk("R11 other register: sum kept", rv, 32'h146);
      get(2, rv); chk("R11 other register: load kept", rv, 32'hCAFEF00D);

      // R9 memory mode rejected
      do_reset();
      load(0, 32'h5); load(3, 32'h7);
      exec_check(1, 3, 0);
      send(8'h01); send(8'h18);
      chk("R9 err set", {31'd0, err}, 32'd1);
      chk("R9 no done", {31'd0, done}, 32'd0);
      get(0, rv); chk("R9 register unchanged", rv, 32'hFFFFFFFE);
      chk("R9 flags unchanged", {29'd0, sf, zf, of}, {29'd0, esf, ezf, eof});
      send(8'h01); send({2'b10, 3'd3, 3'd0});
      get(0, rv); chk("R9 mode 2 register unchanged", rv, 32'hFFFFFFFE);
      tick(); tick();
      chk("R9 err sticky", {31'd0, err}, 32'd1);

      // R10 unknown opcode, then recovery
      do_reset();
      load(0, 32'h10); load(3, 32'h1);
      send(8'h90);
      chk("R10 unknown opcode err", {31'd0, err}, 32'd1);
      get(0, rv); chk("R10 unknown opcode no change", rv, 32'h10);
      exec_check(0, 3, 0);
      get(0, rv); chk("R10 decoder recovers", rv, 32'h11);

      // R10 broken escape pair
      do_reset();
      load(0, 32'h4); load(3, 32'h2);
      send(8'h0F); send(8'h01);
      chk("R10 bad escape err", {31'd0, err}, 32'd1);
      chk("R10 bad escape no done", {31'd0, done}, 32'd0);
      get(3, rv); chk("R10 bad escape no change", rv, 32'h2);
      exec_check(8, 3, 0);
      get(3, rv); chk("R8 multiply after recovery", rv, 32'h8);

      summary();
      $finish;
   end

endmodule